// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block holds the tag and state arrays of a set-associative cache whose geometry is fixed by three parameters: the number of set-index bits, the number of ways in each set and the number of byte-offset bits. It stores no data. Each request carries an address and an operation. The operation is a load, a store, a modify (a read followed by a write to the same block) or an invalidate. The block looks up the address in its set. On a miss it places the block in a free way, or it replaces the least-recently-used line. One cycle after it accepts the request it reports what happened as a three-valued status, together with the block-aligned addresses of the inserted line and of any displaced line.

Recency is kept with a per-set access clock. Each lookup or fill in a set advances that set's clock, and the line that was touched takes the new clock value as its stamp. On a conflict the line with the smallest stamp is replaced. Three running counters record hits, misses and evictions, so a trace-driven environment can compare totals as well as per-access outcomes.

Top module: `cache_tag_ctrl`

## Requirements
- R1: An address splits, from most to least significant, into tag, set index (SET_BITS bits) and byte offset (OFF_BITS bits). The inserted and victim addresses are reported with the offset bits cleared. The victim address is rebuilt from the victim's stored tag and the set index.
- R2: After reset every line is invalid and the hit, miss and eviction counters read zero. The first access to any address is a miss with status 0.
- R3: A load (op 0) or store (op 1) to a valid line with a matching tag returns status 1, with a victim address of 0 and the block address as the inserted address. It adds one to the hit counter.
- R4: A miss in a set that still has an invalid way fills the lowest-numbered invalid way. It returns status 0 with a victim address of 0 and adds one to the miss counter.
- R5: A miss in a full set replaces the valid line with the smallest stamp. It returns status 2 with that line's block address as the victim, and adds one to both the miss and the eviction counters.
- R6: Every load, store or modify advances its set's access clock: by 1 for a load or store, by 2 for a modify. The line that hits or is filled takes the new clock value as its stamp, so the recency order follows hits as well as fills.
- R7: A modify (op 2) counts as two accesses to the same block. It is either two hits (status 1, hit counter +2), or a miss handled as in R4 or R5 followed by a hit (miss counter +1, hit counter +1).
- R8: An invalidate (op 3) clears the valid bit of a matching line. It returns status 1 with that line's block address as the victim when a line matched, and status 0 with a victim of 0 when none did. The inserted address reads 0. It leaves the counters and the set clock unchanged, and a later miss to that set refills the freed way without an eviction.
- R9: req_ready is low during reset and high otherwise. A request is accepted when req_valid and req_ready are both high. done rises in the cycle after acceptance and stays high for exactly one cycle.
- R10: Sets are independent: a fill, hit or eviction in one set never changes the lines or the recency order of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 load, 1 store, 2 modify, 3 invalidate |
| req_addr | input | ADDR_W | Byte address |
| done | output | 1 | Result valid, one-cycle pulse |
| rsp_status | output | 2 | 0 insert, 1 hit, 2 insert with eviction |
| rsp_victim | output | ADDR_W | Block address of displaced or invalidated line |
| rsp_insert | output | ADDR_W | Block address of the accessed block |
| hit_count | output | CNT_W | Running hit total |
| miss_count | output | CNT_W | Running miss total |
| evict_count | output | CNT_W | Running eviction total |

## Verification
The lookup, line update, response fields, done pulse and counter increments for an accepted request all land on the clock edge that accepts it. They are therefore all visible one cycle after acceptance. The bench drives each request on a falling edge, lets one rising edge accept it, and samples status, addresses, done and all three counters on the following falling edge. An idle falling edge after that confirms that done has dropped. A reference model in the bench, updated in request order, supplies every expected value, both for the directed LRU, modify and invalidate cases and for a long pseudo-random sweep over three conflicting tags per set.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_MODIFY = 2'd2,
    OP_INVAL  = 2'd3
  } cache_op_e;

  typedef enum logic [1:0] {
    ST_INSERT = 2'd0,
    ST_HIT    = 2'd1,
    ST_EVICT  = 2'd2
  } cache_status_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 6,
  parameter int OFF_BITS = 6,
  localparam int TAG_W   = ADDR_W - SET_BITS - OFF_BITS
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [TAG_W-1:0]    tag,
  output logic [SET_BITS-1:0] set_idx,
  output logic [ADDR_W-1:0]   blk_addr
);
  assign tag      = addr[ADDR_W-1 -: TAG_W];
  assign set_idx  = addr[OFF_BITS +: SET_BITS];
  assign blk_addr = {addr[ADDR_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
endmodule

// File: rtl/cache_way_select.sv
module cache_way_select #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int TS_W  = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0][TS_W-1:0]  stamps,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       has_free,
  output logic [WAY_W-1:0]           free_way,
  output logic [WAY_W-1:0]           lru_way
);
  logic [WAYS-1:0] match;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = vld[g] && (tags[g] == look_tag);
    end
  endgenerate

  assign hit      = |match;
  assign has_free = ~&vld;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) hit_way = WAY_W'(i);
      if (!vld[i])  free_way = WAY_W'(i);
    end
  end

  always_comb begin
    lru_way = '0;
    for (int i = 1; i < WAYS; i++) begin
      if (stamps[i] < stamps[lru_way]) lru_way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 6,
  parameter int WAYS     = 4,
  parameter int OFF_BITS = 6,
  parameter int TS_W     = 16,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              done,
  output logic [1:0]        rsp_status,
  output logic [ADDR_W-1:0] rsp_victim,
  output logic [ADDR_W-1:0] rsp_insert,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]            vld_q   [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0][TS_W-1:0]  stamp_q [SETS];
  logic [TS_W-1:0]            clk_q   [SETS];

  logic [TAG_W-1:0]    a_tag;
  logic [SET_BITS-1:0] a_set;
  logic [ADDR_W-1:0]   a_blk;
  logic                fire, is_inval, is_mod;
  logic                way_hit, way_free;
  logic [WAY_W-1:0]    hit_way, free_way, lru_way, tgt_way;
  logic [TS_W-1:0]     clk_next;
  logic [ADDR_W-1:0]   victim_addr;
  logic [CNT_W-1:0]    hit_inc;

  cache_addr_split #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS)
  ) u_split (
    .addr(req_addr), .tag(a_tag), .set_idx(a_set), .blk_addr(a_blk)
  );

  cache_way_select #(
    .WAYS(WAYS), .TAG_W(TAG_W), .TS_W(TS_W)
  ) u_sel (
    .vld(vld_q[a_set]), .tags(tag_q[a_set]), .stamps(stamp_q[a_set]),
    .look_tag(a_tag), .hit(way_hit), .hit_way(hit_way),
    .has_free(way_free), .free_way(free_way), .lru_way(lru_way)
  );

  assign req_ready   = !rst;
  assign fire        = req_valid && req_ready;
  assign is_inval    = (req_op == OP_INVAL);
  assign is_mod      = (req_op == OP_MODIFY);
  assign clk_next    = clk_q[a_set] + (is_mod ? TS_W'(2) : TS_W'(1));
  assign tgt_way     = way_hit ? hit_way : (way_free ? free_way : lru_way);
  assign victim_addr = {tag_q[a_set][lru_way], a_set, {OFF_BITS{1'b0}}};
  assign hit_inc     = way_hit ? (is_mod ? CNT_W'(2) : CNT_W'(1))
                               : (is_mod ? CNT_W'(1) : CNT_W'(0));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]   <= '0;
        tag_q[s]   <= '0;
        stamp_q[s] <= '0;
        clk_q[s]   <= '0;
      end
      done        <= 1'b0;
      rsp_status  <= ST_INSERT;
      rsp_victim  <= '0;
      rsp_insert  <= '0;
      hit_count   <= '0;
      miss_count  <= '0;
      evict_count <= '0;
    end else begin
      done <= fire;
      if (fire) begin
        if (is_inval) begin
          if (way_hit) vld_q[a_set][hit_way] <= 1'b0;
          rsp_status <= way_hit ? ST_HIT : ST_INSERT;
          rsp_victim <= way_hit ? a_blk : '0;
          rsp_insert <= '0;
        end else begin
          clk_q[a_set]            <= clk_next;
          vld_q[a_set][tgt_way]   <= 1'b1;
          tag_q[a_set][tgt_way]   <= a_tag;
          stamp_q[a_set][tgt_way] <= clk_next;
          rsp_insert              <= a_blk;
          hit_count               <= hit_count + hit_inc;
          if (way_hit) begin
            rsp_status <= ST_HIT;
            rsp_victim <= '0;
          end else if (way_free) begin
            rsp_status <= ST_INSERT;
            rsp_victim <= '0;
            miss_count <= miss_count + CNT_W'(1);
          end else begin
            rsp_status  <= ST_EVICT;
            rsp_victim  <= victim_addr;
            miss_count  <= miss_count + CNT_W'(1);
            evict_count <= evict_count + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 6,
  parameter int CNT_W    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              done,
  input logic [1:0]        rsp_status,
  input logic [ADDR_W-1:0] rsp_victim,
  input logic [ADDR_W-1:0] rsp_insert,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic [CNT_W-1:0]  evict_count
);
  logic fire;
  assign fire = req_valid && req_ready;

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    fire |=> done);  // R9
  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(fire));  // R9
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (rsp_status != 2'd3));  // R5
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    done |-> (rsp_insert[OFF_BITS-1:0] == '0 && rsp_victim[OFF_BITS-1:0] == '0));  // R1
  AST_EVICT_IS_MISS: assert property (@(posedge clk) disable iff (rst)
    evict_count <= miss_count);  // R5
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(fire) && $past(req_op) != 2'd3) |->
      (miss_count == $past(miss_count) + CNT_W'(rsp_status != 2'd1)));  // R4
  AST_EVICT_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(fire) && $past(req_op) != 2'd3) |->
      (evict_count == $past(evict_count) + CNT_W'(rsp_status == 2'd2)));  // R5
  AST_INVAL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    ($past(fire) && $past(req_op) == 2'd3) |->
      ($stable(hit_count) && $stable(miss_count) && $stable(evict_count)));  // R8
  AST_HIT_MONO: assert property (@(posedge clk) disable iff (rst)
    hit_count >= $past(hit_count));  // R3
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(
  .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .done(done), .rsp_status(rsp_status),
  .rsp_victim(rsp_victim), .rsp_insert(rsp_insert), .hit_count(hit_count),
  .miss_count(miss_count), .evict_count(evict_count)
);

// File: tb/cache_tag_ctrl_tb.sv
module cache_tag_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int SB  = 2;
  localparam int NW  = 2;
  localparam int OB  = 4;
  localparam int CW  = 32;
  localparam int NS  = 1 << SB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic          done;
  logic [1:0]    rsp_status;
  logic [AW-1:0] rsp_victim, rsp_insert;
  logic [CW-1:0] hit_count, miss_count, evict_count;

  int nchk = 0;
  int nerr = 0;

  bit m_vld   [NS][NW];
  int m_tag   [NS][NW];
  int m_stamp [NS][NW];
  int m_clk   [NS];
  int m_hit = 0, m_miss = 0, m_ev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tag_ctrl #(
    .ADDR_W(AW), .SET_BITS(SB), .WAYS(NW), .OFF_BITS(OB), .TS_W(16), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .done(done), .rsp_status(rsp_status),
    .rsp_victim(rsp_victim), .rsp_insert(rsp_insert), .hit_count(hit_count),
    .miss_count(miss_count), .evict_count(evict_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input int op, input int addr, input string req, output int es);
    int s, t, blk, hw, fw, lw, tw, ev, ei, inc;
    s   = (addr >> OB) & (NS - 1);
    t   = addr >> (OB + SB);
    blk = addr & ~((1 << OB) - 1);
    hw  = -1;
    for (int w = 0; w < NW; w++) if (m_vld[s][w] && m_tag[s][w] == t) hw = w;
    if (op == 3) begin
      ei = 0;
      if (hw >= 0) begin m_vld[s][hw] = 1'b0; es = 1; ev = blk; end
      else begin es = 0; ev = 0; end
    end else begin
      inc = (op == 2) ? 2 : 1;
      m_clk[s] += inc;
      ei = blk;
      ev = 0;
      if (hw >= 0) begin
        es = 1; tw = hw; m_hit += inc;
      end else begin
        fw = -1;
        for (int w = NW - 1; w >= 0; w--) if (!m_vld[s][w]) fw = w;
        m_miss++;
        if (op == 2) m_hit++;
        if (fw >= 0) begin
          es = 0; tw = fw;
        end else begin
          lw = 0;
          for (int w = 1; w < NW; w++) if (m_stamp[s][w] < m_stamp[s][lw]) lw = w;
          es = 2; tw = lw; m_ev++;
          ev = (m_tag[s][lw] << (OB + SB)) | (s << OB);
        end
      end
      m_vld[s][tw] = 1'b1; m_tag[s][tw] = t; m_stamp[s][tw] = m_clk[s];
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "done", int'(done), 1);
    chk(req, "status", int'(rsp_status), es);
    chk(req, "victim", int'(rsp_victim), ev);
    chk(req, "insert", int'(rsp_insert), ei);
    chk(req, "hits", int'(hit_count), m_hit);
    chk(req, "misses", int'(miss_count), m_miss);
    chk(req, "evictions", int'(evict_count), m_ev);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int st;
    bit [15:0] lf;
    for (int s = 0; s < NS; s++) begin
      m_clk[s] = 0;
      for (int w = 0; w < NW; w++) begin m_vld[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "ready in reset", int'(req_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "ready", int'(req_ready), 1);
    chk("R2", "done idle", int'(done), 0);
    chk("R2", "hits", int'(hit_count), 0);
    chk("R2", "misses", int'(miss_count), 0);
    chk("R2", "evictions", int'(evict_count), 0);

    access(0, 16'h0005, "R2", st);
    chk("R1", "aligned insert", int'(rsp_insert), 16'h0000);
    access(0, 16'h0048, "R4", st);
    chk("R4", "fill status", st, 0);
    access(0, 16'h0008, "R3", st);
    chk("R3", "hit status", st, 1);
    access(0, 16'h0080, "R6", st);
    chk("R5", "LRU victim", int'(rsp_victim), 16'h0040);
    @(negedge clk);
    chk("R9", "done one cycle", int'(done), 0);
    access(2, 16'h0010, "R7", st);
    access(2, 16'h0014, "R7", st);
    chk("R7", "modify double hit", st, 1);
    access(1, 16'h0090, "R10", st);
    chk("R10", "other set fills free way", st, 0);
    access(0, 16'h0001, "R10", st);
    chk("R10", "set0 untouched hit", st, 1);
    access(3, 16'h0083, "R8", st);
    chk("R8", "inval found", st, 1);
    access(3, 16'h0083, "R8", st);
    chk("R8", "inval absent", st, 0);
    access(0, 16'h00C1, "R8", st);
    chk("R8", "refill without eviction", st, 0);

    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int op, addr;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op = (lf[2:0] == 3'd7) ? 3 : int'(lf[4:3]) % 3;
      addr = ((int'(lf[8:5]) % 3) << (OB + SB)) | (int'(lf[10:9]) << OB) | int'(lf[14:11]);
      access(op, addr, "R5", st);
    end
    chk("R7", "final hits", int'(hit_count), m_hit);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule